// File: doc/BRIEF.md
# Latched Channel Fault Status and Interrupt Controller

This block sits between a background channel scanner and a host register port. On each scan strobe the scanner presents three per-channel health vectors: output signal present, excitation present, and accuracy test passed. The block forces every channel that is not enabled in an active-channel mask to read healthy. It then keeps each of the three groups in a host-readable status register in which a 1 means healthy and a 0 means a fault.

The first fresh fault in a group freezes that group's register. The frozen snapshot stays put until the host reads it, so the host always sees the condition that caused the alarm. While a group is frozen, further scans are ignored for that group. After the read, the next scan strobe loads the conditions of that moment, including any recoveries. A fresh fault also requests a bus interrupt on a programmable priority line from 1 to 7. On the acknowledge cycle the block presents a programmable 8-bit vector. Only one request is outstanding until it is acknowledged.

A heartbeat register is also included. While background testing is enabled, it is reloaded with 55h after every period of `HB_CYC` cycles. The host can clear it to confirm that the reloads continue.

Top module: `fault_status_irq`

## Requirements
- R1: Three status registers hold one bit per channel (bit i = channel i), with 1 = healthy and 0 = fault: address 0 for signal presence, address 1 for excitation presence, address 2 for accuracy test. All bits read 1 after reset. The registers are read-only, and a host write to them has no effect.
- R2: The active-channel mask (address 3, bit i = channel i, reset 0) forces every channel whose mask bit is 0 to read 1 in all three groups after any scan strobe that updates that group.
- R3: When a scan strobe turns any bit of an unfrozen group from 1 to 0, that group freezes. An interrupt request is raised from the next cycle on if the level register is valid at that strobe.
- R4: While a group is frozen, its register value does not change, whatever the later scan strobes carry.
- R5: A host read of a status address unfreezes that group (a fresh fault in the same cycle keeps it frozen). The next scan strobe then loads the current masked conditions, recoveries included.
- R6: The interrupt level register (address 4, 8 bits, reset 0) drives `irq_lvl` with its value when it is 1 to 7. Value 0 or any value above 7 gives `irq_lvl` = 0, and a fault seen at such a time leaves no request behind.
- R7: The vector register (address 5, 8 bits, reset 0) appears on `irq_vec` during a cycle in which `irq_ack` is high and a request is active. Otherwise `irq_vec` is 0.
- R8: An acknowledge removes the request from the next cycle on. Fresh faults before the acknowledge do not queue a second request, and a fresh fault after the acknowledge raises a new one.
- R9: Heartbeat register (address 6, 8 bits, reset 0): while `bg_test_en` is high, a counter reloads it with 55h every `HB_CYC` cycles. A host write stores the low 8 bits, unless a reload happens in the same cycle, in which case the reload wins. While disabled, no reload occurs and the counter restarts.
- R10: Addresses 7 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_stb | input | 1 | Scanner result strobe, one cycle |
| sig_ok | input | NCH | Per-channel signal present (1 = healthy) |
| exc_ok | input | NCH | Per-channel excitation present |
| acc_ok | input | NCH | Per-channel accuracy test passed |
| bg_test_en | input | 1 | Background testing enabled (heartbeat runs) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status reads unfreeze) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from `reg_addr` |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_lvl | output | 3 | Active request priority, 0 = none |
| irq_vec | output | 8 | Vector during acknowledge |

## Verification
Scan patterns are chosen to tell latching apart from plain sampling. A fault followed by a recovery-plus-new-fault strobe must leave the first snapshot visible. A fault strobed into a second group while a request is pending must not produce a second request, and the same fault after an acknowledge must. Faults on masked channels must never appear. Faults are also strobed with level values 0 and 9, and the level is then raised to a valid value, which separates "request blocked at the source" from "request hidden at the output". The heartbeat is exercised through reloads, host clears and disable periods, so that the reload timing is compared cycle by cycle.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int unsigned NGRP = 3;
  localparam int unsigned AW   = 4;

  typedef enum logic [AW-1:0] {
    A_SIG  = 4'd0,
    A_EXC  = 4'd1,
    A_ACC  = 4'd2,
    A_MASK = 4'd3,
    A_LVL  = 4'd4,
    A_VEC  = 4'd5,
    A_BEAT = 4'd6
  } fsi_addr_e;

  localparam logic [7:0] BEAT_MARK = 8'h55;
  localparam logic [7:0] LVL_MAX   = 8'd7;
endpackage

// File: rtl/fsi_latch.sv
module fsi_latch #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_stb,
  input  logic [NCH-1:0] raw_ok,
  input  logic [NCH-1:0] active,
  input  logic           rd_hit,
  output logic [NCH-1:0] stat,
  output logic           frozen,
  output logic           new_fault
);
  logic [NCH-1:0] eff_ok;
  logic [NCH-1:0] stat_q;
  logic           frz_q, frz_d;
  logic           load_en;

  always_comb begin
    eff_ok    = raw_ok | ~active;
    load_en   = scan_stb & ~frz_q;
    new_fault = load_en & (|(stat_q & ~eff_ok));
    frz_d     = frz_q;
    if (rd_hit)    frz_d = 1'b0;
    if (new_fault) frz_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '1;
      frz_q  <= 1'b0;
    end else begin
      if (load_en) stat_q <= eff_ok;
      frz_q <= frz_d;
    end
  end

  assign stat   = stat_q;
  assign frozen = frz_q;
endmodule

// File: rtl/fsi_irq.sv
module fsi_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_any,
  input  logic [7:0] lvl_reg,
  input  logic       ack,
  output logic [2:0] irq_lvl
);
  import fsi_pkg::*;
  logic lvl_ok;
  logic pend_q, pend_d;

  always_comb begin
    lvl_ok = (lvl_reg != 8'd0) && (lvl_reg <= LVL_MAX);
    pend_d = pend_q;
    if (ack) pend_d = 1'b0;
    if (fault_any && lvl_ok) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_lvl = (pend_q && lvl_ok) ? lvl_reg[2:0] : 3'd0;
endmodule

// File: rtl/fsi_beat.sv
module fsi_beat #(
  parameter int unsigned HB_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] beat
);
  import fsi_pkg::*;
  localparam int unsigned CW = (HB_CYC > 2) ? $clog2(HB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HB_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    beat_q, beat_d;
  logic          tick;

  always_comb begin
    tick   = en && (cnt_q == LAST);
    cnt_d  = cnt_q + 1'b1;
    if (!en || tick) cnt_d = '0;
    beat_d = beat_q;
    if (wr)   beat_d = wdata;
    if (tick) beat_d = BEAT_MARK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      beat_q <= 8'd0;
    end else begin
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
    end
  end

  assign beat = beat_q;
endmodule

// File: rtl/fault_status_irq.sv
module fault_status_irq #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned DW     = 16,
  parameter int unsigned HB_CYC = 3000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_stb,
  input  logic [NCH-1:0] sig_ok,
  input  logic [NCH-1:0] exc_ok,
  input  logic [NCH-1:0] acc_ok,
  input  logic          bg_test_en,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_ack,
  output logic [2:0]    irq_lvl,
  output logic [7:0]    irq_vec
);
  import fsi_pkg::*;

  logic [NGRP-1:0][NCH-1:0] raw;
  logic [NGRP-1:0][NCH-1:0] stat;
  logic [NGRP-1:0]          frz;
  logic [NGRP-1:0]          nf;
  logic [NCH-1:0]           mask_q;
  logic [7:0]               lvl_q, vec_q, beat;
  logic                     wr_mask, wr_lvl, wr_vec, wr_beat;

  assign raw[0] = sig_ok;
  assign raw[1] = exc_ok;
  assign raw[2] = acc_ok;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    fsi_latch #(.NCH(NCH)) lat_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_stb (scan_stb),
      .raw_ok   (raw[g]),
      .active   (mask_q),
      .rd_hit   (reg_rd && (reg_addr == AW'(g))),
      .stat     (stat[g]),
      .frozen   (frz[g]),
      .new_fault(nf[g])
    );
  end

  always_comb begin
    wr_mask = reg_wr && (reg_addr == A_MASK);
    wr_lvl  = reg_wr && (reg_addr == A_LVL);
    wr_vec  = reg_wr && (reg_addr == A_VEC);
    wr_beat = reg_wr && (reg_addr == A_BEAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      lvl_q  <= 8'd0;
      vec_q  <= 8'd0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[NCH-1:0];
      if (wr_lvl)  lvl_q  <= reg_wdata[7:0];
      if (wr_vec)  vec_q  <= reg_wdata[7:0];
    end
  end

  fsi_irq irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_any(|nf),
    .lvl_reg  (lvl_q),
    .ack      (irq_ack),
    .irq_lvl  (irq_lvl)
  );

  fsi_beat #(.HB_CYC(HB_CYC)) beat_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (bg_test_en),
    .wr   (wr_beat),
    .wdata(reg_wdata[7:0]),
    .beat (beat)
  );

  assign irq_vec = (irq_ack && (irq_lvl != 3'd0)) ? vec_q : 8'd0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SIG:   reg_rdata = DW'(stat[0]);
      A_EXC:   reg_rdata = DW'(stat[1]);
      A_ACC:   reg_rdata = DW'(stat[2]);
      A_MASK:  reg_rdata = DW'(mask_q);
      A_LVL:   reg_rdata = DW'(lvl_q);
      A_VEC:   reg_rdata = DW'(vec_q);
      A_BEAT:  reg_rdata = DW'(beat);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fault_status_irq_chk.sv
module fault_status_irq_chk #(
  parameter int unsigned NCH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scan_stb,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [3:0]          reg_addr,
  input logic                irq_ack,
  input logic [2:0]          irq_lvl,
  input logic [7:0]          irq_vec,
  input logic [2:0][NCH-1:0] stat,
  input logic [2:0]          frz,
  input logic [NCH-1:0]      mask_q,
  input logic [7:0]          lvl_q,
  input logic [7:0]          vec_q,
  input logic [7:0]          beat
);
  import fsi_pkg::*;

  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R4
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz[g] && !(reg_rd && reg_addr == AW'(g))) |=> $stable(stat[g]));
    // R2
    inactive_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_stb && !frz[g]) |=> &(stat[g] | $past(mask_q)));
    // R3
    freeze_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frz[g]) |-> $past(scan_stb));
  end

  // R6
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl != 3'd0) |-> (irq_lvl == lvl_q[2:0] && lvl_q <= LVL_MAX));
  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !scan_stb) |=> (irq_lvl == 3'd0));
  // R7
  vec_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_lvl != 3'd0) |-> (irq_vec == vec_q));
  // R7
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |-> (irq_vec == 8'd0));
  // R9
  beat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(beat) |-> (beat == BEAT_MARK || $past(reg_wr && reg_addr == A_BEAT)));
endmodule

bind fault_status_irq fault_status_irq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .irq_ack(irq_ack),
  .irq_lvl(irq_lvl), .irq_vec(irq_vec), .stat(stat), .frz(frz),
  .mask_q(mask_q), .lvl_q(lvl_q), .vec_q(vec_q), .beat(beat)
);

// File: tb/fault_status_irq_tb_top.sv
module fault_status_irq_tb_top;
  localparam int NCH = 8;
  localparam int DW = 16;
  localparam int HB = 40;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_stb = 1'b0;
  logic [NCH-1:0] sig_ok = '1, exc_ok = '1, acc_ok = '1;
  logic bg_test_en = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, irq_ack = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [2:0] irq_lvl;
  logic [7:0] irq_vec;

  fault_status_irq #(.NCH(NCH), .DW(DW), .HB_CYC(HB)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .sig_ok(sig_ok),
    .exc_ok(exc_ok), .acc_ok(acc_ok), .bg_test_en(bg_test_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [NCH-1:0] m_stat [3];
  bit m_frz [3];
  logic [NCH-1:0] m_mask;
  logic [7:0] m_lvl, m_vec, m_hb;
  int m_cnt;
  bit m_pend;
  logic [NCH-1:0] m_raw, m_eff;
  bit m_nf, m_set, m_tick;

  function automatic bit lvl_valid(input logic [7:0] l);
    return (l >= 8'd1) && (l <= 8'd7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin m_stat[g] = '1; m_frz[g] = 1'b0; end
      m_mask = '0; m_lvl = 8'd0; m_vec = 8'd0; m_hb = 8'd0; m_cnt = 0; m_pend = 1'b0;
    end else begin
      m_nf = 1'b0;
      for (int g = 0; g < 3; g++) begin
        m_raw = (g == 0) ? sig_ok : (g == 1) ? exc_ok : acc_ok;
        m_eff = m_raw | ~m_mask;
        m_set = scan_stb && !m_frz[g] && ((m_stat[g] & ~m_eff) != '0);
        if (scan_stb && !m_frz[g]) m_stat[g] = m_eff;
        if (m_set) begin m_frz[g] = 1'b1; m_nf = 1'b1; end
        else if (reg_rd && reg_addr == 4'(g)) m_frz[g] = 1'b0;
      end
      if (m_nf && lvl_valid(m_lvl)) m_pend = 1'b1;
      else if (irq_ack) m_pend = 1'b0;
      m_tick = bg_test_en && (m_cnt == HB - 1);
      if (!bg_test_en || m_tick) m_cnt = 0; else m_cnt = m_cnt + 1;
      if (m_tick) m_hb = 8'h55;
      else if (reg_wr && reg_addr == 4'd6) m_hb = reg_wdata[7:0];
      if (reg_wr && reg_addr == 4'd3) m_mask = reg_wdata[NCH-1:0];
      if (reg_wr && reg_addr == 4'd4) m_lvl = reg_wdata[7:0];
      if (reg_wr && reg_addr == 4'd5) m_vec = reg_wdata[7:0];
    end
  end

  function automatic logic [DW-1:0] m_rdata(input logic [3:0] a);
    case (a)
      4'd0: return DW'(m_stat[0]);
      4'd1: return DW'(m_stat[1]);
      4'd2: return DW'(m_stat[2]);
      4'd3: return DW'(m_mask);
      4'd4: return DW'(m_lvl);
      4'd5: return DW'(m_vec);
      4'd6: return DW'(m_hb);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [2:0] el;
      el = (m_pend && lvl_valid(m_lvl)) ? m_lvl[2:0] : 3'd0;
      check(cur_req, "irq_lvl", int'(irq_lvl), int'(el));
      check("R7", "irq_vec", int'(irq_vec), int'((irq_ack && el != 3'd0) ? m_vec : 8'd0));
      check(cur_req, "reg_rdata", int'(reg_rdata), int'(m_rdata(reg_addr)));
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #2 check(req, "read", int'(reg_rdata), exp);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] s, input logic [7:0] e, input logic [7:0] c);
    @(negedge clk); sig_ok = s; exc_ok = e; acc_ok = c; scan_stb = 1'b1;
    @(negedge clk); scan_stb = 1'b0;
  endtask

  task automatic irq_chk(input int exp, input string req);
    #2 check(req, "irq_lvl", int'(irq_lvl), exp);
  endtask

  task automatic ack_chk(input int exp_vec);
    @(negedge clk); irq_ack = 1'b1;
    #2 check("R7", "vector on ack", int'(irq_vec), exp_vec);
    @(negedge clk); irq_ack = 1'b0;
    #2 check("R8", "request after ack", int'(irq_lvl), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R1";
    rd_chk(4'd0, 16'h00FF, "R1");
    rd_chk(4'd2, 16'h00FF, "R1");
    bus_wr(4'd3, 16'h000F);
    bus_wr(4'd4, 16'h0003);
    bus_wr(4'd5, 16'h00A5);
    strobe(8'hFF, 8'hFF, 8'hFF);
    irq_chk(0, "R3");
    cur_req = "R3";
    strobe(8'hBD, 8'hFF, 8'hFF);         // ch1 fault, ch6 masked fault
    irq_chk(3, "R3");
    cur_req = "R4";
    strobe(8'hFB, 8'hFF, 8'hFF);         // ch1 recovers, ch2 fails: frozen
    irq_chk(3, "R4");
    ack_chk(8'hA5);
    cur_req = "R8";
    strobe(8'hFB, 8'hFE, 8'hFF);         // exc ch0 fault after ack
    irq_chk(3, "R8");
    rd_chk(4'd0, 16'h00FD, "R4");        // snapshot, ch6 reads 1 (R2)
    ack_chk(8'hA5);
    cur_req = "R5";
    strobe(8'hFB, 8'hFE, 8'hFF);         // unfrozen sig: ch2 fresh fault
    irq_chk(3, "R5");
    rd_chk(4'd0, 16'h00FB, "R5");
    ack_chk(8'hA5);
    strobe(8'hFF, 8'hFE, 8'hFF);         // recovery applied
    rd_chk(4'd0, 16'h00FF, "R5");
    cur_req = "R6";
    bus_wr(4'd4, 16'h0009);
    strobe(8'hFE, 8'hFE, 8'hFF);
    irq_chk(0, "R6");
    rd_chk(4'd0, 16'h00FE, "R6");
    bus_wr(4'd4, 16'h0000);
    strobe(8'hFF, 8'hFE, 8'hFF);
    strobe(8'hFE, 8'hFE, 8'hFF);
    irq_chk(0, "R6");
    bus_wr(4'd4, 16'h0007);
    irq_chk(0, "R6");
    cur_req = "R1";
    bus_wr(4'd0, 16'h0000);
    rd_chk(4'd0, 16'h00FE, "R1");
    cur_req = "R10";
    rd_chk(4'd7, 0, "R10");
    rd_chk(4'd15, 0, "R10");
    cur_req = "R2";
    bus_wr(4'd3, 16'h0000);
    strobe(8'h00, 8'h00, 8'h00);
    rd_chk(4'd0, 16'h00FF, "R2");
    rd_chk(4'd1, 16'h00FE, "R2");
    strobe(8'h00, 8'h00, 8'h00);
    rd_chk(4'd1, 16'h00FF, "R2");
    cur_req = "R3";
    bus_wr(4'd3, 16'h00FF);
    strobe(8'hFF, 8'hFF, 8'h7F);
    irq_chk(7, "R3");
    rd_chk(4'd2, 16'h007F, "R3");
    ack_chk(8'hA5);
    cur_req = "R9";
    rd_chk(4'd6, 0, "R9");
    @(negedge clk); bg_test_en = 1'b1;
    repeat (45) @(negedge clk);
    rd_chk(4'd6, 16'h0055, "R9");
    bus_wr(4'd6, 16'h0000);
    rd_chk(4'd6, 0, "R9");
    bus_wr(4'd6, 16'h0012);
    rd_chk(4'd6, 16'h0012, "R9");
    repeat (45) @(negedge clk);
    rd_chk(4'd6, 16'h0055, "R9");
    @(negedge clk); bg_test_en = 1'b0;
    bus_wr(4'd6, 16'h0000);
    repeat (60) @(negedge clk);
    rd_chk(4'd6, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule